// File: doc/BRIEF.md
# Bridge Power State and Downstream Gating Controller

This block holds the power-management control/status register of a bridge function and decides, request by request, whether a downstream transaction is claimed or master-aborted. Software reads and writes the register, plus a small bridge-control register, through a single-cycle configuration port. The power state field accepts only the two supported states, full-on and off. Writes that ask for the two intermediate states complete normally but leave the state unchanged.

While the state is anything other than full-on, every downstream request is master-aborted except type 0 configuration. Each abort produces a one-cycle log pulse and sets a sticky abort flag, which software clears by writing 1 to it. A secondary-bus-reset control bit drives a hot-reset request toward the link state machine for as long as the bit stays set. A wake-enable bit is kept across functional reset and is cleared only by power-on reset. It has no effect on any hardware behaviour.

Top module: `bridge_pm_gate`

## Requirements
- R1: The power state field occupies bits 1:0 of the power register (`cfg_sel`=0). The encodings are 00 = D0, 01 = D1, 10 = D2 and 11 = D3, and the field resets to D0. The field only ever holds D0 or D3.
- R2: A write of 01 or 10 to bits 1:0 completes, but the power state keeps its previous value. Writes of 00 or 11 take effect on the next cycle.
- R3: A request of type memory (00), I/O (01) or type 1 config (11) is claimed in D0 and master-aborted in D3. A type 0 config request (10) is always claimed.
- R4: Each master-abort raises `ma_log_pulse` for exactly one cycle and sets the sticky abort flag at bit 1 of the control register (`cfg_sel`=1). Writing 1 to that bit clears the flag, but an abort in the same cycle wins. Writing 0 leaves the flag unchanged.
- R5: The wake-enable bit (bit 8 of the power register) is written independently of the state field and reads back its value. It never changes claim or abort decisions.
- R6: After power-on reset the power register reads 0000_0008h. Bit 3 always reads 1, and all other bits except 8 and 1:0 read 0 whatever is written. Bits 31:2 of the control register read 0.
- R7: Bit 0 of the control register is the secondary bus reset bit. `hot_reset_req` follows it on the cycle after the write and stays high until software clears the bit.
- R8: A functional reset (`rst_n` low) returns the state to D0 and clears the bus reset bit and the abort flag, but keeps the wake-enable bit. A power-on reset (`por_n` low) clears everything.
- R9: Each request sampled with `req_valid` high yields exactly one response on the next cycle (`rsp_valid` high), gated by the state held when the request was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low functional reset |
| por_n | input | 1 | Synchronous active-low power-on reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 power register, 1 control register |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Combinational read data for the selected register |
| req_valid | input | 1 | Downstream request present |
| req_type | input | 2 | Request kind: 00 mem, 01 I/O, 10 cfg type 0, 11 cfg type 1 |
| rsp_valid | output | 1 | Decision valid, one cycle after the request |
| rsp_claim | output | 1 | 1 = claimed, 0 = master-aborted |
| ma_log_pulse | output | 1 | One-cycle pulse per master-abort |
| hot_reset_req | output | 1 | Hot-reset request to the link state machine |

## Verification
On every cycle the assertions check the following. The state field only ever holds a legal value. Dropped D1/D2 writes leave it stable. Claim and abort decisions follow the sampled state and request type. Every log pulse is matched by a set sticky flag. The hot-reset output tracks the last control write. Only the bench scenarios can show the read-back values of the register layouts and the retention of wake-enable across a functional reset. They also cover the same-cycle race between an abort and a clear of the flag, and a scoreboard that matches each response to its request in order.

// File: rtl/bpg_pkg.sv
// Package: shared types and register bit positions for the bridge power gate.
// Assumes 32-bit configuration registers.
package bpg_pkg;
    localparam int REG_W      = 32;
    localparam int PS_W       = 2;
    localparam int PS_LSB     = 0;
    localparam int FIXED_BIT  = 3;
    localparam int WAKE_BIT   = 8;
    localparam int SBR_BIT    = 0;
    localparam int MALOG_BIT  = 1;

    typedef enum logic [PS_W-1:0] {
        PS_D0 = 2'b00,
        PS_D1 = 2'b01,
        PS_D2 = 2'b10,
        PS_D3 = 2'b11
    } pm_state_e;

    typedef enum logic [1:0] {
        RQ_MEM  = 2'b00,
        RQ_IO   = 2'b01,
        RQ_CFG0 = 2'b10,
        RQ_CFG1 = 2'b11
    } req_kind_e;
endpackage

// File: rtl/bpg_pm_reg.sv
// Module: power state field and sticky wake-enable bit.
// Assumes a single-cycle write strobe already qualified by register select.
// Writes requesting D1 or D2 are accepted but leave the state unchanged.
module bpg_pm_reg
    import bpg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output pm_state_e        state,
    output logic             wake_en
);
    logic [PS_W-1:0] req_ps;
    logic            ps_ok;

    assign req_ps = wdata[PS_LSB +: PS_W];

    // Accept only supported target states.
    always_comb begin
        ps_ok = (req_ps == PS_D0) || (req_ps == PS_D3);
    end

    // Power state: cleared by either reset, updated only on a legal write.
    always_ff @(posedge clk) begin
        if (!rst_n || !por_n)
            state <= PS_D0;
        else if (wr_en && ps_ok)
            state <= pm_state_e'(req_ps);
    end

    // Wake enable: survives functional reset, cleared only at power-on.
    always_ff @(posedge clk) begin
        if (!por_n)
            wake_en <= 1'b0;
        else if (wr_en)
            wake_en <= wdata[WAKE_BIT];
    end
endmodule

// File: rtl/bpg_gate.sv
// Module: per-request claim/abort decision with one register stage.
// Assumes at most one request per cycle; the decision uses the state
// held at the sampling edge.
module bpg_gate
    import bpg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  req_kind_e req_type,
    input  pm_state_e state,
    output logic      rsp_valid,
    output logic      rsp_claim,
    output logic      abort_pulse
);
    logic claim_now;

    // Type 0 config always passes; everything else needs D0.
    always_comb begin
        claim_now = (state == PS_D0) || (req_type == RQ_CFG0);
    end

    // Register the decision and the abort pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_claim   <= 1'b0;
            abort_pulse <= 1'b0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_claim   <= req_valid && claim_now;
            abort_pulse <= req_valid && !claim_now;
        end
    end
endmodule

// File: rtl/bpg_bctl.sv
// Module: bus reset control bit and sticky master-abort flag.
// Assumes abort_evt is asserted on the same edge the decision is registered;
// a set from abort_evt wins over a write-one-to-clear in the same cycle.
module bpg_bctl
    import bpg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             abort_evt,
    output logic             sbr,
    output logic             ma_flag
);
    // Secondary bus reset bit: plain read/write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sbr <= 1'b0;
        else if (wr_en)
            sbr <= wdata[SBR_BIT];
    end

    // Sticky abort flag: set by events, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ma_flag <= 1'b0;
        else if (abort_evt)
            ma_flag <= 1'b1;
        else if (wr_en && wdata[MALOG_BIT])
            ma_flag <= 1'b0;
    end
endmodule

// File: rtl/bridge_pm_gate.sv
// Module: top of the bridge power gate. It holds the power register and the
// control register and gates downstream requests by power state.
// Assumes synchronous active-low resets; the power-on reset implies a
// functional reset.
module bridge_pm_gate
    import bpg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic             cfg_wr_en,
    input  logic             cfg_sel,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             req_valid,
    input  logic [1:0]       req_type,
    output logic             rsp_valid,
    output logic             rsp_claim,
    output logic             ma_log_pulse,
    output logic             hot_reset_req
);
    logic      func_rst_n;
    pm_state_e pm_state;
    logic      wake_en;
    logic      sbr;
    logic      ma_flag;
    logic      pm_wr;
    logic      ctl_wr;

    assign func_rst_n = rst_n && por_n;
    assign pm_wr      = cfg_wr_en && !cfg_sel;
    assign ctl_wr     = cfg_wr_en && cfg_sel;

    bpg_pm_reg u_pm (
        .clk     (clk),
        .rst_n   (rst_n),
        .por_n   (por_n),
        .wr_en   (pm_wr),
        .wdata   (cfg_wdata),
        .state   (pm_state),
        .wake_en (wake_en)
    );

    bpg_gate u_gate (
        .clk         (clk),
        .rst_n       (func_rst_n),
        .req_valid   (req_valid),
        .req_type    (req_kind_e'(req_type)),
        .state       (pm_state),
        .rsp_valid   (rsp_valid),
        .rsp_claim   (rsp_claim),
        .abort_pulse (ma_log_pulse)
    );

    // The flag is set on the same edge that registers the abort decision.
    logic abort_now;
    assign abort_now = req_valid && (pm_state != PS_D0) &&
                       (req_kind_e'(req_type) != RQ_CFG0);

    bpg_bctl u_bctl (
        .clk       (clk),
        .rst_n     (func_rst_n),
        .wr_en     (ctl_wr),
        .wdata     (cfg_wdata),
        .abort_evt (abort_now),
        .sbr       (sbr),
        .ma_flag   (ma_flag)
    );

    assign hot_reset_req = sbr;

    // Read mux: assemble the selected register; unused bits are zero.
    always_comb begin
        cfg_rdata = '0;
        if (!cfg_sel) begin
            cfg_rdata[PS_LSB +: PS_W] = pm_state;
            cfg_rdata[FIXED_BIT]      = 1'b1;
            cfg_rdata[WAKE_BIT]       = wake_en;
        end else begin
            cfg_rdata[SBR_BIT]   = sbr;
            cfg_rdata[MALOG_BIT] = ma_flag;
        end
    end
endmodule

// File: rtl/bridge_pm_gate_chk.sv
// Module: assertion checker for bridge_pm_gate, attached with bind.
// Assumes it observes the top's ports plus the internal state and flag.
module bridge_pm_gate_chk
    import bpg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             por_n,
    input logic             cfg_wr_en,
    input logic             cfg_sel,
    input logic [REG_W-1:0] cfg_wdata,
    input logic             req_valid,
    input logic [1:0]       req_type,
    input logic             rsp_valid,
    input logic             rsp_claim,
    input logic             ma_log_pulse,
    input logic             hot_reset_req,
    input logic [1:0]       pm_state,
    input logic             ma_flag
);
    // R1
    legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (pm_state == 2'b00) || (pm_state == 2'b11));

    // R2
    drop_write_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (cfg_wr_en && !cfg_sel && (cfg_wdata[1:0] == 2'b01 || cfg_wdata[1:0] == 2'b10))
        |=> $stable(pm_state));

    // R3
    d0_claim_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (req_valid && pm_state == 2'b00) |=> (rsp_valid && rsp_claim));

    // R3
    cfg0_claim_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (req_valid && req_type == 2'b10) |=> rsp_claim);

    // R3
    off_abort_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (req_valid && pm_state != 2'b00 && req_type != 2'b10)
        |=> (ma_log_pulse && !rsp_claim));

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        ma_log_pulse |-> ma_flag);

    // R9
    one_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        req_valid |=> rsp_valid);

    // R7
    hot_reset_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (cfg_wr_en && cfg_sel) |=> (hot_reset_req == $past(cfg_wdata[0])));
endmodule

bind bridge_pm_gate bridge_pm_gate_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .por_n         (por_n),
    .cfg_wr_en     (cfg_wr_en),
    .cfg_sel       (cfg_sel),
    .cfg_wdata     (cfg_wdata),
    .req_valid     (req_valid),
    .req_type      (req_type),
    .rsp_valid     (rsp_valid),
    .rsp_claim     (rsp_claim),
    .ma_log_pulse  (ma_log_pulse),
    .hot_reset_req (hot_reset_req),
    .pm_state      (pm_state),
    .ma_flag       (ma_flag)
);

// File: tb/bridge_pm_gate_bench.sv
// Bench: scoreboard. Request tasks push the expected decision into a queue,
// and a monitor pops and compares on each response.
module bridge_pm_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [1:0]  req_type = '0;
    logic        rsp_valid, rsp_claim, ma_log_pulse, hot_reset_req;

    int total = 0;
    int bad = 0;
    logic exp_d0 = 1'b1;
    logic [1:0] exp_q[$];

    always #5 clk = ~clk;

    bridge_pm_gate u_bridge_pm_gate (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_type(req_type),
        .rsp_valid(rsp_valid), .rsp_claim(rsp_claim),
        .ma_log_pulse(ma_log_pulse), .hot_reset_req(hot_reset_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_wdata = '0;
    endtask

    task automatic cfg_read(input logic sel, input string req, input logic [31:0] exp);
        @(negedge clk);
        cfg_sel = sel;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    // Driver: push the expected {claim, abort} and present one request.
    task automatic send_req(input logic [1:0] t);
        logic cl;
        @(negedge clk);
        cl = exp_d0 || (t == 2'b10);
        exp_q.push_back({cl, !cl});
        req_valid = 1'b1; req_type = t;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare each response with the head of the queue (R3, R4, R9).
    always @(negedge clk) begin
        if (rsp_valid) begin
            if (exp_q.size() == 0)
                check("R9 unexpected response", 32'(rsp_valid), 32'd0);
            else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                check("R3 claim", 32'(rsp_claim), 32'(e[1]));
                check("R4 abort pulse", 32'(ma_log_pulse), 32'(e[0]));
            end
        end else if (ma_log_pulse) begin
            check("R4 pulse without response", 32'(ma_log_pulse), 32'd0);
        end
    end

    initial begin
        #100000;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
        // R6 / R1 reset values
        cfg_read(1'b0, "R6 reset power reg", 32'h0000_0008);
        cfg_read(1'b1, "R6 reset control reg", 32'h0);
        check("R7 hot reset idle", 32'(hot_reset_req), 32'd0);
        // R3 all kinds claimed in D0
        for (int i = 0; i < 4; i++) send_req(2'(i));
        // R1 / R5 / R6 write everything ones: D3, wake on, reserved still zero
        cfg_write(1'b0, 32'hFFFF_FFFF);
        exp_d0 = 1'b0;
        cfg_read(1'b0, "R6 reserved zero", 32'h0000_010B);
        // R3 gating in D3
        for (int i = 0; i < 4; i++) send_req(2'(i));
        repeat (2) @(negedge clk);
        cfg_read(1'b1, "R4 flag set", 32'h2);
        cfg_write(1'b1, 32'h0);
        cfg_read(1'b1, "R4 write zero keeps flag", 32'h2);
        cfg_write(1'b1, 32'h2);
        cfg_read(1'b1, "R4 flag cleared", 32'h0);
        // R2 D1 and D2 dropped; R5 wake bit still written
        cfg_write(1'b0, 32'h0000_0101);
        cfg_read(1'b0, "R2 D1 dropped", 32'h0000_010B);
        cfg_write(1'b0, 32'h0000_0002);
        cfg_read(1'b0, "R2 D2 dropped, R5 wake cleared", 32'h0000_000B);
        // R4 abort and clear in the same cycle: set wins
        @(negedge clk);
        exp_q.push_back(2'b01);
        req_valid = 1'b1; req_type = 2'b00;
        cfg_wr_en = 1'b1; cfg_sel = 1'b1; cfg_wdata = 32'h2;
        @(negedge clk);
        req_valid = 1'b0; cfg_wr_en = 1'b0; cfg_wdata = '0;
        cfg_read(1'b1, "R4 set beats clear", 32'h2);
        // R5 wake bit has no effect on gating
        cfg_write(1'b0, 32'h0000_0100);
        exp_d0 = 1'b1;
        cfg_read(1'b0, "R1 back to D0", 32'h0000_0108);
        send_req(2'b01);
        cfg_write(1'b0, 32'h0000_0102);
        cfg_read(1'b0, "R2 D2 from D0 dropped", 32'h0000_0108);
        // R7 hot reset level
        cfg_write(1'b1, 32'h1);
        check("R7 hot reset raised", 32'(hot_reset_req), 32'd1);
        repeat (5) @(negedge clk);
        check("R7 hot reset held", 32'(hot_reset_req), 32'd1);
        cfg_write(1'b1, 32'h0);
        check("R7 hot reset cleared", 32'(hot_reset_req), 32'd0);
        // R8 functional reset keeps wake enable
        cfg_write(1'b0, 32'h0000_0103);
        cfg_write(1'b1, 32'h1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        exp_d0 = 1'b1;
        cfg_read(1'b0, "R8 functional reset keeps wake", 32'h0000_0108);
        cfg_read(1'b1, "R8 control cleared", 32'h0);
        check("R8 hot reset dropped", 32'(hot_reset_req), 32'd0);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        cfg_read(1'b0, "R8 power-on clears wake", 32'h0000_0008);
        repeat (3) @(negedge clk);
        check("R9 all responses seen", 32'(exp_q.size()), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule